// File: doc/BRIEF.md
# Spare Area Status-Byte Repacker

This block converts the out-of-band byte stream of a NAND page handled in chunks between two layouts. In the linear layout, the spare regions of all chunks sit back to back. Each chunk's region holds its metadata bytes first and its parity bytes after them. In the expanded layout, every chunk's spare region is followed by a gap of four status bytes.

In insert mode, the block reads the linear stream and writes the expanded stream, filling each gap with zero bytes. In extract mode, it reads the expanded stream and writes only the spare bytes. It drops each gap and reports the first gap byte as that chunk's correction status, tagged with the chunk number.

Both streams use valid/ready handshakes and carry one byte per transfer. A frame starts with the first input byte accepted while the block is idle. The mode, the per-chunk spare size and the chunk count are captured at that moment. When the last slot of the final chunk has been handled, a one-cycle done strobe follows.

Top module: `spare_gap_repacker`

## Requirements
- R1: After reset, out_valid, stat_valid and frame_done are low, and in_ready is high so that a frame can start.
- R2: In insert mode (mode_extract = 0), the output carries each chunk's cfg_spare input bytes in arrival order, followed by exactly four bytes of value 0x00, for cfg_chunks chunks.
- R3: In extract mode (mode_extract = 1), the input carries each chunk as cfg_spare bytes plus four gap bytes. The output carries only the spare bytes, in order, and no gap byte appears on it.
- R4: In extract mode, gap byte 0 of chunk n (expanded offset cfg_spare + n*(cfg_spare+4)) is reported on stat_data with stat_index = n, in a one-cycle stat_valid pulse one cycle after that byte is accepted. Chunks are reported in increasing order.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. No byte is lost or duplicated across a stall.
- R6: In insert mode, in_ready is low during the four gap slots of a chunk, so that no input byte is consumed while zeros are emitted.
- R7: frame_done pulses for exactly one cycle per frame, one cycle after the last slot of the final chunk has been handled.
- R8: Mode, spare size and chunk count are sampled when the first byte of a frame is accepted. Changing them during the frame has no effect on that frame.
- R9: The mode encoding is mode_extract = 0 for insert and 1 for extract.
- R10: stat_valid is never raised during an insert-mode frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_extract | input | 1 | 0 = insert gaps, 1 = strip gaps and capture status |
| cfg_spare | input | 8 | Spare bytes per chunk (1..MAX_SPARE) |
| cfg_chunks | input | 5 | Chunks per frame (1..MAX_CHUNKS) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts output byte |
| stat_valid | output | 1 | Status byte captured (one-cycle pulse) |
| stat_data | output | 8 | Captured status byte |
| stat_index | output | 4 | Chunk number of the captured status |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume the following about the inputs:
- cfg_spare lies between 1 and MAX_SPARE, and cfg_chunks lies between 1 and MAX_CHUNKS, whenever a frame starts.
- In extract mode, the upstream supplies whole chunks, gap bytes included.

With a zero spare size, a frame could start on a gap slot without input. The stimulus therefore sets only legal sizes, including the limits 1 and MAX_SPARE and the full chunk count. It waits for frame_done before it loads the next frame's configuration. It scrambles the configuration inputs only after a frame's first byte has been accepted.

// File: rtl/spare_gap_pkg.sv
package spare_gap_pkg;

    localparam int GAP_BYTES = 4;

    typedef enum logic {
        MODE_INSERT  = 1'b0,
        MODE_EXTRACT = 1'b1
    } repack_mode_e;

    typedef enum logic [1:0] {
        SLOT_DATA     = 2'd0,
        SLOT_GAP_HEAD = 2'd1,
        SLOT_GAP_TAIL = 2'd2
    } slot_kind_e;

    typedef struct packed {
        logic emit;
        logic consume;
        logic capture;
    } slot_action_t;

    function automatic slot_action_t slot_action(repack_mode_e m, slot_kind_e k);
        slot_action_t a;
        a = '0;
        case (k)
            SLOT_DATA: begin
                a.emit    = 1'b1;
                a.consume = 1'b1;
            end
            SLOT_GAP_HEAD: begin
                a.emit    = (m == MODE_INSERT);
                a.consume = (m == MODE_EXTRACT);
                a.capture = (m == MODE_EXTRACT);
            end
            default: begin
                a.emit    = (m == MODE_INSERT);
                a.consume = (m == MODE_EXTRACT);
            end
        endcase
        return a;
    endfunction

endpackage

// File: rtl/repack_sequencer.sv
module repack_sequencer
    import spare_gap_pkg::*;
#(
    parameter int MAX_SPARE  = 128,
    parameter int MAX_CHUNKS = 16,
    localparam int SW = $clog2(MAX_SPARE + 1),
    localparam int NW = $clog2(MAX_CHUNKS + 1),
    localparam int IW = $clog2(MAX_CHUNKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  repack_mode_e  cfg_mode,
    input  logic [SW-1:0] cfg_spare,
    input  logic [NW-1:0] cfg_chunks,
    input  logic          step,
    output repack_mode_e  cur_mode,
    output slot_kind_e    cur_kind,
    output logic [IW-1:0] chunk_idx,
    output logic          last_slot,
    output logic          busy
);
    localparam int PW = $clog2(MAX_SPARE + GAP_BYTES);

    logic [PW-1:0] pos_q;
    logic [IW-1:0] chunk_q;
    logic          busy_q;
    repack_mode_e  mode_q;
    logic [SW-1:0] spare_q;
    logic [NW-1:0] chunks_q;

    logic [SW-1:0] eff_spare;
    logic [NW-1:0] eff_chunks;
    logic [PW-1:0] spare_pos;
    logic [PW-1:0] end_pos;
    logic          end_of_chunk;
    logic          last_chunk;

    // While idle the live configuration is used, so the first slot decodes correctly
    assign cur_mode   = busy_q ? mode_q : cfg_mode;
    assign eff_spare  = busy_q ? spare_q : cfg_spare;
    assign eff_chunks = busy_q ? chunks_q : cfg_chunks;

    assign spare_pos    = PW'(eff_spare);
    assign end_pos      = spare_pos + PW'(GAP_BYTES - 1);
    assign end_of_chunk = (pos_q == end_pos);
    assign last_chunk   = (NW'(chunk_q) == (eff_chunks - NW'(1)));
    assign last_slot    = end_of_chunk && last_chunk;

    always_comb begin
        if (pos_q < spare_pos)       cur_kind = SLOT_DATA;
        else if (pos_q == spare_pos) cur_kind = SLOT_GAP_HEAD;
        else                         cur_kind = SLOT_GAP_TAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            chunk_q  <= '0;
            busy_q   <= 1'b0;
            mode_q   <= MODE_INSERT;
            spare_q  <= '0;
            chunks_q <= '0;
        end else if (step) begin
            if (!busy_q) begin
                busy_q   <= 1'b1;
                mode_q   <= cfg_mode;
                spare_q  <= cfg_spare;
                chunks_q <= cfg_chunks;
            end
            if (end_of_chunk) begin
                pos_q <= '0;
                if (last_chunk) begin
                    chunk_q <= '0;
                    busy_q  <= 1'b0;
                end else begin
                    chunk_q <= chunk_q + IW'(1);
                end
            end else begin
                pos_q <= pos_q + PW'(1);
            end
        end
    end

    assign chunk_idx = chunk_q;
    assign busy      = busy_q;

endmodule

// File: rtl/byte_out_stage.sv
module byte_out_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          slot_free
);
    logic          valid_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            data_q  <= load_data;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign slot_free = !valid_q || out_ready;
    assign out_valid = valid_q;
    assign out_data  = data_q;

endmodule

// File: rtl/status_capture.sv
module status_capture #(
    parameter int DW = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] cap_byte,
    input  logic [IW-1:0] cap_index,
    output logic          stat_valid,
    output logic [DW-1:0] stat_data,
    output logic [IW-1:0] stat_index
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_valid <= 1'b0;
            stat_data  <= '0;
            stat_index <= '0;
        end else begin
            stat_valid <= capture;
            if (capture) begin
                stat_data  <= cap_byte;
                stat_index <= cap_index;
            end
        end
    end

endmodule

// File: rtl/spare_gap_repacker.sv
module spare_gap_repacker
    import spare_gap_pkg::*;
#(
    parameter int MAX_SPARE  = 128,
    parameter int MAX_CHUNKS = 16,
    localparam int SW = $clog2(MAX_SPARE + 1),
    localparam int NW = $clog2(MAX_CHUNKS + 1),
    localparam int IW = $clog2(MAX_CHUNKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_extract,
    input  logic [SW-1:0] cfg_spare,
    input  logic [NW-1:0] cfg_chunks,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [7:0]    out_data,
    input  logic          out_ready,
    output logic          stat_valid,
    output logic [7:0]    stat_data,
    output logic [IW-1:0] stat_index,
    output logic          frame_done
);
    repack_mode_e  seq_mode;
    slot_kind_e    seq_kind;
    logic [IW-1:0] seq_chunk;
    logic          seq_last;
    logic          seq_busy;
    slot_action_t  act;
    logic          slot_free;
    logic          step;
    logic          done_q;

    repack_sequencer #(
        .MAX_SPARE  (MAX_SPARE),
        .MAX_CHUNKS (MAX_CHUNKS)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_mode   (repack_mode_e'(mode_extract)),
        .cfg_spare  (cfg_spare),
        .cfg_chunks (cfg_chunks),
        .step       (step),
        .cur_mode   (seq_mode),
        .cur_kind   (seq_kind),
        .chunk_idx  (seq_chunk),
        .last_slot  (seq_last),
        .busy       (seq_busy)
    );

    assign act = slot_action(seq_mode, seq_kind);

    // A slot that emits needs a free output register; a slot that consumes needs input
    assign in_ready = act.consume && (!act.emit || slot_free);
    assign step     = act.consume ? (in_valid && in_ready) : slot_free;

    byte_out_stage #(.DW(8)) out_i (
        .clk       (clk),
        .rst       (rst),
        .load      (step && act.emit),
        .load_data (act.consume ? in_data : 8'h00),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .slot_free (slot_free)
    );

    status_capture #(.DW(8), .IW(IW)) stat_i (
        .clk        (clk),
        .rst        (rst),
        .capture    (step && act.capture),
        .cap_byte   (in_data),
        .cap_index  (seq_chunk),
        .stat_valid (stat_valid),
        .stat_data  (stat_data),
        .stat_index (stat_index)
    );

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= step && seq_last;
    end

    assign frame_done = done_q;

endmodule

// File: rtl/repack_checker.sv
module repack_checker
    import spare_gap_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         out_valid,
    input logic [7:0]   out_data,
    input logic         out_ready,
    input logic         stat_valid,
    input logic         frame_done,
    input logic         seq_busy,
    input repack_mode_e seq_mode
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !stat_valid && !frame_done));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    assert_stat_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        stat_valid |=> !stat_valid);

    assert_no_stat_insert_R10: assert property (@(posedge clk) disable iff (rst)
        stat_valid |-> (seq_busy && seq_mode == MODE_EXTRACT));

endmodule

bind spare_gap_repacker repack_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .stat_valid (stat_valid),
    .frame_done (frame_done),
    .seq_busy   (seq_busy),
    .seq_mode   (seq_mode)
);

// File: tb/spare_gap_repacker_tb_top.sv
module spare_gap_repacker_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_extract = 1'b0;
    logic [7:0] cfg_spare = 8'd8;
    logic [4:0] cfg_chunks = 5'd1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;
    logic       stat_valid;
    logic [7:0] stat_data;
    logic [3:0] stat_index;
    logic       frame_done;

    spare_gap_repacker dut_i (
        .clk(clk), .rst(rst), .mode_extract(mode_extract), .cfg_spare(cfg_spare),
        .cfg_chunks(cfg_chunks), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .stat_valid(stat_valid), .stat_data(stat_data), .stat_index(stat_index),
        .frame_done(frame_done)
    );

    always #10 clk = ~clk;

    int  checks = 0;
    int  errors = 0;
    int  done_count = 0;
    int  stat_in_insert = 0;
    bit  insert_frame = 1'b1;
    bit  stall_en = 1'b0;
    bit  finished = 1'b0;
    bit  held_pending = 1'b0;
    int  held_byte = 0;
    int  exp_out[$];
    int  exp_stat[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        #3;
        if (!rst) begin
            if (held_pending) begin
                check(out_valid && (int'(out_data) == held_byte), "R5 stall hold", int'(out_data), held_byte);
                held_pending = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (exp_out.size() == 0) begin
                    check(1'b0, "R2 R3 unexpected byte", int'(out_data), -1);
                end else begin
                    int e;
                    e = exp_out.pop_front();
                    check(int'(out_data) == e, "R2 R3 R6 byte order", int'(out_data), e);
                end
            end else if (out_valid && !out_ready) begin
                held_pending = 1'b1;
                held_byte    = int'(out_data);
            end
            if (stat_valid) begin
                if (insert_frame) begin
                    stat_in_insert++;
                end else if (exp_stat.size() == 0) begin
                    check(1'b0, "R4 unexpected status", int'(stat_index) * 256 + int'(stat_data), -1);
                end else begin
                    int s;
                    s = exp_stat.pop_front();
                    check(int'(stat_index) * 256 + int'(stat_data) == s, "R4 status index/data",
                          int'(stat_index) * 256 + int'(stat_data), s);
                end
            end
            if (frame_done) done_count++;
        end
    end

    // Output back-pressure
    initial begin
        forever begin
            @(negedge clk);
            #1;
            out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
    end

    // Drive one input byte; entered at negedge+1
    task automatic send_byte(input logic [7:0] b, input bit bubble);
        bit accepted;
        if (bubble) begin
            in_valid = 1'b0;
            @(negedge clk);
            #1;
        end
        in_valid = 1'b1;
        in_data  = b;
        accepted = 1'b0;
        while (!accepted) begin
            #3;
            accepted = in_ready;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic run_frame(input bit ext, input int spare, input int chunks, input int fid,
                             input bit bubbles, input bit stall, input bit scramble);
        int d0;
        int k;
        @(negedge clk);
        #1;
        mode_extract = ext;
        cfg_spare    = 8'(spare);
        cfg_chunks   = 5'(chunks);
        insert_frame = !ext;
        stall_en     = stall;
        stat_in_insert = 0;
        d0 = done_count;
        // Expected results for the whole frame
        for (int c = 0; c < chunks; c++) begin
            for (int i = 0; i < spare; i++) exp_out.push_back((fid * 37 + c * 11 + i * 3 + 1) & 255);
            if (!ext) for (int g = 0; g < 4; g++) exp_out.push_back(0);
            else exp_stat.push_back(c * 256 + ((fid * 13 + c * 29 + 7) & 255));
        end
        k = 0;
        for (int c = 0; c < chunks; c++) begin
            for (int i = 0; i < spare; i++) begin
                send_byte(8'((fid * 37 + c * 11 + i * 3 + 1) & 255), bubbles && (k % 3 == 2));
                k++;
                if (scramble && k == 1) begin
                    mode_extract = !ext;
                    cfg_spare    = 8'(spare + 3);
                    cfg_chunks   = 5'(1);
                end
            end
            if (ext) begin
                send_byte(8'((fid * 13 + c * 29 + 7) & 255), 1'b0);
                for (int g = 1; g < 4; g++) send_byte(8'(8'hA0 + g), bubbles && (g == 2));
            end
        end
        in_valid = 1'b0;
        for (int w = 0; w < 4000 && !(done_count > d0 && exp_out.size() == 0); w++) @(negedge clk);
        repeat (4) @(negedge clk);
        stall_en = 1'b0;
        check(done_count == d0 + 1, "R7 one done per frame", done_count - d0, 1);
        check(exp_out.size() == 0, ext ? "R3 all spare bytes out" : "R2 R6 all bytes out", exp_out.size(), 0);
        if (ext) check(exp_stat.size() == 0, "R4 all status reported", exp_stat.size(), 0);
        else     check(stat_in_insert == 0, "R9 R10 no status in insert mode", stat_in_insert, 0);
        if (scramble) check(exp_out.size() == 0 && done_count == d0 + 1, "R8 config sampled at start",
                            exp_out.size(), 0);
        exp_out.delete();
        exp_stat.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        check(!out_valid && !stat_valid && !frame_done, "R1 outputs idle after reset",
              {out_valid, stat_valid, frame_done}, 0);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        run_frame(1'b0,   8,  2, 1, 1'b0, 1'b0, 1'b0);
        run_frame(1'b1,   8,  2, 2, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0,   1,  3, 3, 1'b0, 1'b1, 1'b0);
        run_frame(1'b1,  16,  4, 4, 1'b1, 1'b1, 1'b0);
        run_frame(1'b0,   5, 16, 5, 1'b1, 1'b1, 1'b1);
        run_frame(1'b1, 128,  2, 6, 1'b0, 1'b1, 1'b1);
        run_frame(1'b1,   1, 16, 7, 1'b1, 1'b1, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule